// File: doc/BRIEF.md
# Triggered Pattern Output Controller

This block drives a 16-bit output pattern that changes only when external timer compare-match pulses arrive. Software loads the next pattern into a staging register. The output bus is split into four nibble-wide groups. Each group follows one of four timer channels, picked by a 2-bit field in a control register. When the chosen channel pulses, the group copies its staged bits onto the output.

A per-bit enable register sets which output bits may take staged data. Bits whose enable is clear keep the value they last held. All three registers sit behind a small word-wide write/read port. A standby input stops all activity and keeps every register, including the trigger-select settings.

Top module: `pattern_trig_ctrl`

## Requirements
- R1: After reset the output bus is 0x0000, the staging register and the enable register read 0x0000, and the control register reads 0x00FF.
- R2: Register selector 0 reaches the 16-bit staging register, 1 the 16-bit enable register, and 2 the 8-bit control register. Writes take effect at the clock edge. Reads are combinational. Control bits above bit 7 read as 0. Selector 3 is reserved: it reads 0x0000 and ignores writes.
- R3: Output groups are laid out as follows: group 3 is bits 15:12, group 2 is bits 11:8, group 1 is bits 7:4 and group 0 is bits 3:0. Control bits 7:6, 5:4, 3:2 and 1:0 select the trigger of groups 3, 2, 1 and 0. Codes 00, 01, 10 and 11 select compare-match input bit 0, 1, 2 and 3.
- R4: A one-cycle pulse on a group's selected channel copies that group's enabled staging bits to the output at the clock edge that samples the pulse.
- R5: An output bit whose enable bit is 0 keeps its previous value when its group is triggered.
- R6: A pulse on a channel that no group selects leaves the output unchanged.
- R7: When a staging-register write and a trigger fall in the same cycle, the output receives the old staging contents. The new contents are used by later triggers.
- R8: While standby is high, compare-match pulses and register writes are ignored, the output holds, and the control register keeps its value.
- R9: Several groups that select the same channel all update on a single pulse of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Freezes outputs and registers while high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_sel |
| cmp_match | input | 4 | Single-cycle compare-match pulses, one per timer channel |
| pat_out | output | 16 | Registered output pattern |

## Verification
Two events can land in the same cycle: a register write to the staging register and a trigger pulse that reads it. The bench raises the write strobe and a channel pulse on the same falling edge. It then checks that the triggered group shows the old staged nibble, and that a read-back shows the new word. A second pulse on the same channel must then move the new nibble to the output.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    localparam int PTC_GROUPS  = 4;
    localparam int PTC_GROUP_W = 4;
    localparam int PTC_CHANNELS = 4;

    typedef enum logic [1:0] {
        SEL_NEXT = 2'd0,
        SEL_EN   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ptc_trig_sel.sv
module ptc_trig_sel #(
    parameter int N_CH  = 4,
    parameter int SEL_W = 2
) (
    input  logic [N_CH-1:0]  pulses,
    input  logic [SEL_W-1:0] sel,
    output logic             fire
);
    always_comb begin
        fire = 1'b0;
        for (int c = 0; c < N_CH; c++) begin
            if (sel == SEL_W'(c)) fire = pulses[c];
        end
    end
endmodule

// File: rtl/ptc_group_merge.sv
module ptc_group_merge #(
    parameter int GW = 4
) (
    input  logic          fire,
    input  logic [GW-1:0] cur,
    input  logic [GW-1:0] nxt,
    input  logic [GW-1:0] en,
    output logic [GW-1:0] upd
);
    always_comb begin
        upd = cur;
        if (fire) upd = (nxt & en) | (cur & ~en);
    end
endmodule

// File: rtl/ptc_rd_mux.sv
module ptc_rd_mux #(
    parameter int DW     = 16,
    parameter int CTRL_W = 8
) (
    input  logic [1:0]        sel,
    input  logic [DW-1:0]     nd,
    input  logic [DW-1:0]     en,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [DW-1:0]     rdata
);
    import ptc_pkg::*;
    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_NEXT: rdata = nd;
            SEL_EN:   rdata = en;
            SEL_CTRL: rdata = DW'(ctrl);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pattern_trig_ctrl.sv
module pattern_trig_ctrl
    import ptc_pkg::*;
#(
    parameter int N_GROUPS = PTC_GROUPS,
    parameter int GROUP_W  = PTC_GROUP_W,
    parameter int N_CH     = PTC_CHANNELS,
    localparam int SEL_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int OUT_W   = N_GROUPS * GROUP_W,
    localparam int CTRL_W  = N_GROUPS * SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [OUT_W-1:0] reg_wdata,
    output logic [OUT_W-1:0] reg_rdata,
    input  logic [N_CH-1:0]  cmp_match,
    output logic [OUT_W-1:0] pat_out
);
    typedef struct packed {
        logic [OUT_W-1:0]  nd;
        logic [OUT_W-1:0]  en;
        logic [CTRL_W-1:0] ctrl;
        logic [OUT_W-1:0]  out;
    } state_t;

    state_t s_d, s_q;

    logic [N_GROUPS-1:0] fire_raw;
    logic [OUT_W-1:0]    merged;
    logic [OUT_W-1:0]    en_cur;
    logic [CTRL_W-1:0]   ctrl_cur;

    assign en_cur   = s_q.en;
    assign ctrl_cur = s_q.ctrl;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        ptc_trig_sel #(.N_CH(N_CH), .SEL_W(SEL_W)) sel_i (
            .pulses (cmp_match),
            .sel    (s_q.ctrl[g*SEL_W +: SEL_W]),
            .fire   (fire_raw[g])
        );
        ptc_group_merge #(.GW(GROUP_W)) merge_i (
            .fire (fire_raw[g] & ~standby),
            .cur  (s_q.out[g*GROUP_W +: GROUP_W]),
            .nxt  (s_q.nd[g*GROUP_W +: GROUP_W]),
            .en   (s_q.en[g*GROUP_W +: GROUP_W]),
            .upd  (merged[g*GROUP_W +: GROUP_W])
        );
    end

    ptc_rd_mux #(.DW(OUT_W), .CTRL_W(CTRL_W)) rd_i (
        .sel   (reg_sel),
        .nd    (s_q.nd),
        .en    (s_q.en),
        .ctrl  (s_q.ctrl),
        .rdata (reg_rdata)
    );

    always_comb begin
        s_d     = s_q;
        s_d.out = merged;
        if (reg_we && !standby) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_NEXT: s_d.nd   = reg_wdata;
                SEL_EN:   s_d.en   = reg_wdata;
                SEL_CTRL: s_d.ctrl = reg_wdata[CTRL_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.nd   <= '0;
            s_q.en   <= '0;
            s_q.ctrl <= '1;
            s_q.out  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pat_out = s_q.out;
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
    parameter int OUT_W  = 16,
    parameter int CTRL_W = 8,
    parameter int N_CH   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             standby,
    input logic [1:0]       reg_sel,
    input logic [OUT_W-1:0] reg_rdata,
    input logic [N_CH-1:0]  cmp_match,
    input logic [OUT_W-1:0] pat_out,
    input logic [OUT_W-1:0] en_cur,
    input logic [CTRL_W-1:0] ctrl_cur
);
    assert_disabled_bits_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pat_out ^ $past(pat_out)) & ~$past(en_cur)) == '0));

    assert_standby_output_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> $stable(pat_out));

    assert_standby_keeps_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> $stable(ctrl_cur));

    assert_no_pulse_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_match == '0) |=> $stable(pat_out));

    assert_reserved_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> (reg_rdata == '0));
endmodule

bind pattern_trig_ctrl ptc_checker #(.OUT_W(OUT_W), .CTRL_W(CTRL_W), .N_CH(N_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .cmp_match (cmp_match),
    .pat_out   (pat_out),
    .en_cur    (en_cur),
    .ctrl_cur  (ctrl_cur)
);

// File: tb/pattern_trig_ctrl_tb.sv
`timescale 1ns/1ps
module pattern_trig_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  cmp_match = '0;
    logic [15:0] pat_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pattern_trig_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmp_match(cmp_match), .pat_out(pat_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] sel, input logic [15:0] exp);
        @(negedge clk);
        reg_sel = sel;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [3:0] mask);
        @(negedge clk);
        cmp_match = mask;
        @(negedge clk);
        cmp_match = '0;
    endtask

    task automatic t_reset();
        check("R1 out", pat_out, 16'h0000);
        rd_check("R1 next", 2'd0, 16'h0000);
        rd_check("R1 enable", 2'd1, 16'h0000);
        rd_check("R1 ctrl", 2'd2, 16'h00FF);
    endtask

    task automatic t_regs();
        wr(2'd3, 16'h1234);
        rd_check("R2 reserved", 2'd3, 16'h0000);
        wr(2'd2, 16'hFF3C);
        rd_check("R2 ctrl width", 2'd2, 16'h003C);
        wr(2'd2, 16'h00FF);
        wr(2'd0, 16'hA5C3);
        rd_check("R2 next", 2'd0, 16'hA5C3);
    endtask

    task automatic t_default_trigger();
        pulse(4'b1000);
        check("R5 enable zero", pat_out, 16'h0000);
        wr(2'd1, 16'hFFFF);
        rd_check("R2 enable", 2'd1, 16'hFFFF);
        pulse(4'b0001);
        check("R6 unselected channel", pat_out, 16'h0000);
        pulse(4'b1000);
        check("R4 R9 all groups on ch3", pat_out, 16'hA5C3);
    endtask

    task automatic t_groups();
        wr(2'd2, 16'h00E4);
        wr(2'd0, 16'h1234);
        pulse(4'b0010);
        check("R3 group1 on ch1", pat_out, 16'hA533);
        pulse(4'b0100);
        check("R3 group2 on ch2", pat_out, 16'hA233);
    endtask

    task automatic t_partial();
        wr(2'd1, 16'h0F0F);
        wr(2'd0, 16'hFFFF);
        pulse(4'b1111);
        check("R5 partial enable", pat_out, 16'hAF3F);
    endtask

    task automatic t_collide();
        wr(2'd1, 16'hFFFF);
        wr(2'd0, 16'h1111);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h8888; cmp_match = 4'b0001;
        @(negedge clk);
        reg_we = 1'b0; cmp_match = '0;
        check("R7 old data moved", pat_out, 16'hAF31);
        rd_check("R7 new data stored", 2'd0, 16'h8888);
        pulse(4'b0001);
        check("R7 new data later", pat_out, 16'hAF38);
    endtask

    task automatic t_standby();
        @(negedge clk);
        standby = 1'b1;
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h0000);
        pulse(4'b1111);
        check("R8 output frozen", pat_out, 16'hAF38);
        @(negedge clk);
        standby = 1'b0;
        rd_check("R8 ctrl kept", 2'd2, 16'h00E4);
        rd_check("R8 write ignored", 2'd0, 16'h8888);
        pulse(4'b1000);
        check("R8 resumes", pat_out, 16'h8F38);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_default_trigger();
        t_groups();
        t_partial();
        t_collide();
        t_standby();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule